// File: doc/BRIEF.md
# Delayed Write Transaction Controller

This block sits inside a bus-to-bus bridge and turns single-DWORD writes that must not be posted into delayed transactions. When an initiator first presents such a write, the block claims it and answers with a retry. It records the command and address from the address phase and the byte enables and data from the data phase in a small first-in first-out queue. It then frees the initiator's bus instead of holding it in wait states.

On the far side the block issues the oldest queued write whenever an external ordering input reports that posted traffic allows it. It reissues the write after every retry from the destination until the write is accepted. A programmable attempt limit ends an undeliverable write: the entry is dropped, and a system-error pulse is raised if error reporting is enabled. When the initiator comes back with the same write, the block compares it with the completed oldest entry. A match receives the completion and frees the entry. Anything else is told to retry.

Top module: `delayed_write_ctrl`

## Requirements
- R1: Every data phase (a cycle with `ini_irdy` high after an `ini_frame` strobe) is answered exactly one clock later by a one-cycle response with `ini_devsel` high. A write that does not complete gets `ini_stop` high and `ini_trdy` low, which is a retry. Outside that response cycle the three response outputs are low.
- R2: Command and address are taken in the `ini_frame` cycle. Byte enables and data are taken in the `ini_irdy` cycle. Values on `ini_cmd`/`ini_addr` during the data phase have no effect on the queued write.
- R3: A write that does not complete is queued only if no queued entry has the same command and address and the queue holds fewer than DEPTH entries.
- R4: `tgt_req` is high exactly when the oldest entry exists, has not yet been delivered, and `order_ok` is high. While it is high, `tgt_cmd`/`tgt_addr`/`tgt_be_n`/`tgt_data` carry that entry.
- R5: A `tgt_retry` during `tgt_req` leaves the same entry requested. A `tgt_done` during `tgt_req` marks it delivered, and `tgt_req` falls on the next cycle.
- R6: The attempt limit is 2^SHORT_LOG when `long_limit` is 0 and 2^LONG_LOG when it is 1. The retry that uses up the limit drops the oldest entry, and `sys_err` pulses high for one cycle on the following clock if `serr_en` was high.
- R7: With `serr_en` low an exhausted entry is still dropped, but `sys_err` stays low.
- R8: A repeat whose command, address and byte enables equal those of the delivered oldest entry, and whose enabled data bytes match, gets `ini_devsel` and `ini_trdy`, with `ini_stop` also high only when `ini_multi` was high. The entry is then removed.
- R9: Byte enables are active low, and bit i covers data bits 8i+7..8i. Bytes whose enable bit is 1 take no part in the data comparison. A mismatch in an enabled byte gives a retry.
- R10: A repeat of a queued write that has not yet been delivered gets a retry and adds no entry.
- R11: Entries are issued in arrival order, and the queue never holds more than DEPTH entries.
- R12: While `rst_n` is low the queue is empty and `tgt_req`, `sys_err` and the three initiator response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ini_frame | input | 1 | Address-phase strobe on the initiator side |
| ini_cmd | input | CMD_W | Bus command, taken with ini_frame |
| ini_addr | input | ADDR_W | Address, taken with ini_frame |
| ini_irdy | input | 1 | Data-phase strobe on the initiator side |
| ini_be_n | input | DATA_W/8 | Active-low byte enables, taken with ini_irdy |
| ini_data | input | DATA_W | Write data, taken with ini_irdy |
| ini_multi | input | 1 | Initiator wants more than one DWORD |
| ini_devsel | output | 1 | Access claimed |
| ini_trdy | output | 1 | Write completed |
| ini_stop | output | 1 | Retry or disconnect |
| order_ok | input | 1 | Posted-write ordering permits issuing the oldest entry |
| tgt_req | output | 1 | Oldest entry is being issued on the target side |
| tgt_cmd | output | CMD_W | Command of the oldest entry |
| tgt_addr | output | ADDR_W | Address of the oldest entry |
| tgt_be_n | output | DATA_W/8 | Byte enables of the oldest entry |
| tgt_data | output | DATA_W | Data of the oldest entry |
| tgt_done | input | 1 | Destination accepted the write |
| tgt_retry | input | 1 | Destination asked for a retry |
| long_limit | input | 1 | Selects the long attempt limit |
| serr_en | input | 1 | Allows sys_err to be raised |
| sys_err | output | 1 | One-cycle pulse when a write is abandoned |

## Verification
The properties assume that every `ini_irdy` strobe follows its own `ini_frame` strobe. They also assume that `tgt_done` and `tgt_retry` are never high together and are only raised while `tgt_req` is high. The bench keeps to these assumptions by construction. Each write is a fixed address-cycle, data-cycle, idle sequence, and target replies are chosen only in cycles where its own model predicts a request. Random writes are drawn from a small address and command pool, mixed with repeats of queued entries whose disabled or enabled bytes are perturbed, so that duplicates, full queues, completions and exhausted limits all occur.

// File: rtl/dwc_pkg.sv
// Shared types for the delayed write controller.
// Assumes nothing beyond being compiled before its users.
package dwc_pkg;

    // Phase of the initiator-side capture sequence.
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } ini_phase_e;

    // Registered response returned to the initiator.
    typedef struct packed {
        logic devsel;
        logic trdy;
        logic stop;
    } ini_resp_t;

endpackage

// File: rtl/dwc_queue.sv
// Delayed-transaction queue: a DEPTH-entry circular FIFO of single-DWORD
// writes with a per-entry delivered flag and a parallel command/address
// lookup over all occupied slots.
// Assumes push is never requested when full and pop only when the oldest
// entry is occupied; DEPTH >= 2.
module dwc_queue #(
    parameter int DEPTH  = 4,
    parameter int CMD_W  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CMD_W-1:0]  push_cmd,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [BE_W-1:0]   push_be_n,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              mark_done,
    input  logic [CMD_W-1:0]  look_cmd,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic              full,
    output logic              head_valid,
    output logic              head_done,
    output logic [CMD_W-1:0]  head_cmd,
    output logic [ADDR_W-1:0] head_addr,
    output logic [BE_W-1:0]   head_be_n,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [CMD_W-1:0]  cmd_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [BE_W-1:0]   be_q   [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  occ_q;
    logic [DEPTH-1:0]  done_q;
    logic [DEPTH-1:0]  hit_vec;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Payload storage, written at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            cmd_q[wr_ptr]  <= push_cmd;
            addr_q[wr_ptr] <= push_addr;
            be_q[wr_ptr]   <= push_be_n;
            data_q[wr_ptr] <= push_data;
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            // Occupancy and delivered flags of one slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    occ_q[g]  <= 1'b0;
                    done_q[g] <= 1'b0;
                end else begin
                    if (mark_done && rd_ptr == PTR_W'(g)) done_q[g] <= 1'b1;
                    if (pop && rd_ptr == PTR_W'(g)) begin
                        occ_q[g]  <= 1'b0;
                        done_q[g] <= 1'b0;
                    end
                    if (push && wr_ptr == PTR_W'(g)) begin
                        occ_q[g]  <= 1'b1;
                        done_q[g] <= 1'b0;
                    end
                end
            end
            // Per-slot duplicate detection on command and address.
            assign hit_vec[g] = occ_q[g] && (cmd_q[g] == look_cmd) && (addr_q[g] == look_addr);
        end
    endgenerate

    // Pointer and occupancy-count maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Head view and status.
    always_comb begin
        look_hit   = |hit_vec;
        full       = (cnt_q == CNT_W'(DEPTH));
        head_valid = occ_q[rd_ptr];
        head_done  = done_q[rd_ptr];
        head_cmd   = cmd_q[rd_ptr];
        head_addr  = addr_q[rd_ptr];
        head_be_n  = be_q[rd_ptr];
        head_data  = data_q[rd_ptr];
        count      = cnt_q;
    end

endmodule

// File: rtl/dwc_ini_side.sv
// Initiator-side engine: captures command/address on the address strobe and
// byte enables/data on the data strobe, then decides between completion
// (repeat of the delivered oldest entry) and retry, requesting a queue push
// for new writes. The response is registered one cycle after the data strobe.
// Assumes each data strobe is preceded by its own address strobe.
module dwc_ini_side
    import dwc_pkg::*;
#(
    parameter int CMD_W  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              irdy,
    input  logic [BE_W-1:0]   be_n,
    input  logic [DATA_W-1:0] data,
    input  logic              multi,
    input  logic              look_hit,
    input  logic              full,
    input  logic              head_valid,
    input  logic              head_done,
    input  logic [CMD_W-1:0]  head_cmd,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [BE_W-1:0]   head_be_n,
    input  logic [DATA_W-1:0] head_data,
    output logic [CMD_W-1:0]  cap_cmd,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              push,
    output logic              pop_cmp,
    output logic              devsel,
    output logic              trdy,
    output logic              stop
);
    ini_phase_e       phase_q;
    ini_resp_t        resp_q;
    logic [BE_W-1:0]  byte_ok;
    logic             decide;
    logic             hit_head;

    // Address-phase capture and phase tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_ADDR;
            cap_cmd  <= '0;
            cap_addr <= '0;
        end else if (phase_q == PH_ADDR && frame) begin
            phase_q  <= PH_DATA;
            cap_cmd  <= cmd;
            cap_addr <= addr;
        end else if (phase_q == PH_DATA && irdy) begin
            phase_q  <= PH_ADDR;
        end
    end

    genvar b;
    generate
        for (b = 0; b < BE_W; b++) begin : g_byte
            // A disabled byte always counts as matching.
            assign byte_ok[b] = be_n[b] || (data[b*8 +: 8] == head_data[b*8 +: 8]);
        end
    endgenerate

    // Completion and enqueue decision for the current data phase.
    always_comb begin
        decide   = (phase_q == PH_DATA) && irdy;
        hit_head = head_valid && head_done && (head_cmd == cap_cmd) &&
                   (head_addr == cap_addr) && (head_be_n == be_n) && (&byte_ok);
        pop_cmp  = decide && hit_head;
        push     = decide && !hit_head && !look_hit && !full;
    end

    // Registered one-cycle response to the initiator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (decide) begin
            resp_q.devsel <= 1'b1;
            resp_q.trdy   <= hit_head;
            resp_q.stop   <= !hit_head || multi;
        end else begin
            resp_q <= '0;
        end
    end

    assign devsel = resp_q.devsel;
    assign trdy   = resp_q.trdy;
    assign stop   = resp_q.stop;

endmodule

// File: rtl/dwc_tgt_side.sv
// Target-side engine: requests the oldest undelivered entry while ordering
// allows, counts retries against a selectable power-of-two limit, marks the
// entry delivered on acceptance and abandons it (with an optional one-cycle
// error pulse) when the limit is used up.
// Assumes done and retry are never asserted together.
module dwc_tgt_side #(
    parameter int SHORT_LOG = 24,
    parameter int LONG_LOG  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic head_done,
    input  logic order_ok,
    input  logic tgt_done,
    input  logic tgt_retry,
    input  logic long_limit,
    input  logic serr_en,
    output logic tgt_req,
    output logic mark_done,
    output logic pop_err,
    output logic sys_err
);
    localparam int CNT_W = LONG_LOG;
    localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'((64'd1 << SHORT_LOG) - 64'd1);
    localparam logic [CNT_W-1:0] LONG_M1  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] tries_q;
    logic [CNT_W-1:0] limit_m1;
    logic             last_try;

    // Issue condition and end-of-attempt outcomes.
    always_comb begin
        limit_m1  = long_limit ? LONG_M1 : SHORT_M1;
        last_try  = (tries_q >= limit_m1);
        tgt_req   = head_valid && !head_done && order_ok;
        mark_done = tgt_req && tgt_done;
        pop_err   = tgt_req && tgt_retry && !tgt_done && last_try;
    end

    // Retry counter for the entry at the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (mark_done || pop_err) begin
            tries_q <= '0;
        end else if (tgt_req && tgt_retry) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    // Gated system-error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_err <= 1'b0;
        else        sys_err <= pop_err && serr_en;
    end

endmodule

// File: rtl/delayed_write_ctrl.sv
// Delayed write transaction controller top: ties the initiator engine, the
// delayed-transaction queue and the target engine together. The oldest entry
// leaves the queue either on a matching completion or on an exhausted limit.
// Assumes the input handshakes described in the brief.
module delayed_write_ctrl #(
    parameter int CMD_W     = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 4,
    parameter int SHORT_LOG = 24,
    parameter int LONG_LOG  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ini_frame,
    input  logic [CMD_W-1:0]    ini_cmd,
    input  logic [ADDR_W-1:0]   ini_addr,
    input  logic                ini_irdy,
    input  logic [DATA_W/8-1:0] ini_be_n,
    input  logic [DATA_W-1:0]   ini_data,
    input  logic                ini_multi,
    output logic                ini_devsel,
    output logic                ini_trdy,
    output logic                ini_stop,
    input  logic                order_ok,
    output logic                tgt_req,
    output logic [CMD_W-1:0]    tgt_cmd,
    output logic [ADDR_W-1:0]   tgt_addr,
    output logic [DATA_W/8-1:0] tgt_be_n,
    output logic [DATA_W-1:0]   tgt_data,
    input  logic                tgt_done,
    input  logic                tgt_retry,
    input  logic                long_limit,
    input  logic                serr_en,
    output logic                sys_err
);
    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              push, pop, pop_cmp, pop_err, mark_done;
    logic              look_hit, full, head_valid, head_done;
    logic [CMD_W-1:0]  cap_cmd;
    logic [ADDR_W-1:0] cap_addr;
    logic [CNT_W-1:0]  q_count;

    // Head leaves on completion or abandonment.
    assign pop = pop_cmp || pop_err;

    dwc_ini_side #(
        .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
    ) u_ini (
        .clk(clk), .rst_n(rst_n),
        .frame(ini_frame), .cmd(ini_cmd), .addr(ini_addr),
        .irdy(ini_irdy), .be_n(ini_be_n), .data(ini_data), .multi(ini_multi),
        .look_hit(look_hit), .full(full),
        .head_valid(head_valid), .head_done(head_done),
        .head_cmd(tgt_cmd), .head_addr(tgt_addr),
        .head_be_n(tgt_be_n), .head_data(tgt_data),
        .cap_cmd(cap_cmd), .cap_addr(cap_addr),
        .push(push), .pop_cmp(pop_cmp),
        .devsel(ini_devsel), .trdy(ini_trdy), .stop(ini_stop)
    );

    dwc_queue #(
        .DEPTH(DEPTH), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .BE_W(BE_W), .CNT_W(CNT_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_cmd(cap_cmd), .push_addr(cap_addr),
        .push_be_n(ini_be_n), .push_data(ini_data),
        .pop(pop), .mark_done(mark_done),
        .look_cmd(cap_cmd), .look_addr(cap_addr), .look_hit(look_hit),
        .full(full), .head_valid(head_valid), .head_done(head_done),
        .head_cmd(tgt_cmd), .head_addr(tgt_addr),
        .head_be_n(tgt_be_n), .head_data(tgt_data),
        .count(q_count)
    );

    dwc_tgt_side #(
        .SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)
    ) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .head_valid(head_valid), .head_done(head_done),
        .order_ok(order_ok), .tgt_done(tgt_done), .tgt_retry(tgt_retry),
        .long_limit(long_limit), .serr_en(serr_en),
        .tgt_req(tgt_req), .mark_done(mark_done),
        .pop_err(pop_err), .sys_err(sys_err)
    );

endmodule

// File: rtl/dwc_checker.sv
// Property checker for the delayed write controller, bound to the top.
// Assumes the input handshakes stated in the brief's verification section.
module dwc_checker #(
    parameter int CMD_W  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ini_irdy,
    input logic                ini_multi,
    input logic                ini_devsel,
    input logic                ini_trdy,
    input logic                ini_stop,
    input logic                order_ok,
    input logic                tgt_req,
    input logic [CMD_W-1:0]    tgt_cmd,
    input logic [ADDR_W-1:0]   tgt_addr,
    input logic [DATA_W/8-1:0] tgt_be_n,
    input logic [DATA_W-1:0]   tgt_data,
    input logic                tgt_done,
    input logic                tgt_retry,
    input logic                serr_en,
    input logic                sys_err,
    input logic [CNT_W-1:0]    q_count
);
    // R1: a response always claims and is either completion or stop.
    p_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ini_trdy || ini_stop) |-> ini_devsel);
    p_resp_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ini_devsel |-> (ini_trdy || ini_stop));
    p_resp_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ini_devsel |-> $past(ini_irdy));
    // R8: disconnect with completion only for multi-DWORD requests.
    p_disc_multi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ini_trdy && ini_stop) |-> $past(ini_multi));
    // R4: no issue without ordering permission.
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> order_ok);
    // R5: an outstanding request keeps its payload.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_done && !tgt_retry) |=>
        ($stable(tgt_cmd) && $stable(tgt_addr) && $stable(tgt_be_n) && $stable(tgt_data)));
    // R6: error pulse only after a retry with reporting enabled, one cycle wide.
    p_serr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err |-> $past(tgt_req && tgt_retry && serr_en));
    p_serr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err |=> !sys_err);
    // R11: occupancy never exceeds the depth.
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));
endmodule

bind delayed_write_ctrl dwc_checker #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_dwc_chk (
    .clk(clk), .rst_n(rst_n), .ini_irdy(ini_irdy), .ini_multi(ini_multi),
    .ini_devsel(ini_devsel), .ini_trdy(ini_trdy), .ini_stop(ini_stop),
    .order_ok(order_ok), .tgt_req(tgt_req), .tgt_cmd(tgt_cmd),
    .tgt_addr(tgt_addr), .tgt_be_n(tgt_be_n), .tgt_data(tgt_data),
    .tgt_done(tgt_done), .tgt_retry(tgt_retry), .serr_en(serr_en),
    .sys_err(sys_err), .q_count(q_count)
);

// File: tb/delayed_write_ctrl_bench.sv
// Self-checking bench: directed corner cases followed by seeded random
// traffic, all compared against a cycle model kept in bench functions.
module delayed_write_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int SHORT_LOG  = 3;
    localparam int LONG_LOG   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame = 1'b0, irdy = 1'b0, multi = 1'b0;
    logic [3:0]  cmd = '0, be_n = '0;
    logic [31:0] addr = '0, data = '0;
    logic        order_ok = 1'b0, tgt_done = 1'b0, tgt_retry = 1'b0;
    logic        long_limit = 1'b0, serr_en = 1'b0;
    logic        devsel, trdy, stop, tgt_req, sys_err;
    logic [3:0]  tgt_cmd, tgt_be_n;
    logic [31:0] tgt_addr, tgt_data;

    int n_chk = 0, n_fail = 0, n_comp = 0, n_err = 0, n_dup = 0;
    int tgt_mode = 0;

    // Bench model of the queue and capture state.
    logic [3:0]  m_cmd [DEPTH];
    logic [31:0] m_addr [DEPTH];
    logic [3:0]  m_be [DEPTH];
    logic [31:0] m_data [DEPTH];
    bit          m_done [DEPTH];
    int          mc = 0, ma = 0;
    bit          m_phase = 0;
    logic [3:0]  m_ccmd = '0;
    logic [31:0] m_caddr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    delayed_write_ctrl #(.DEPTH(DEPTH), .SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)) u_delayed_write_ctrl (
        .clk(clk), .rst_n(rst_n), .ini_frame(frame), .ini_cmd(cmd), .ini_addr(addr),
        .ini_irdy(irdy), .ini_be_n(be_n), .ini_data(data), .ini_multi(multi),
        .ini_devsel(devsel), .ini_trdy(trdy), .ini_stop(stop), .order_ok(order_ok),
        .tgt_req(tgt_req), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr), .tgt_be_n(tgt_be_n),
        .tgt_data(tgt_data), .tgt_done(tgt_done), .tgt_retry(tgt_retry),
        .long_limit(long_limit), .serr_en(serr_en), .sys_err(sys_err)
    );

    function automatic logic [31:0] en_mask(input logic [3:0] b);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (!b[i]) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic bit masked_eq(input logic [31:0] a, input logic [31:0] c, input logic [3:0] b);
        return ((a ^ c) & en_mask(b)) == 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_pop();
        for (int k = 0; k < DEPTH - 1; k++) begin
            m_cmd[k] = m_cmd[k+1]; m_addr[k] = m_addr[k+1];
            m_be[k] = m_be[k+1]; m_data[k] = m_data[k+1]; m_done[k] = m_done[k+1];
        end
        mc--;
    endtask

    // One clock: starts just after a falling edge, ends at the next one.
    task automatic step();
        bit exp_req, comp, dup, push, err, dec;
        int lim, r;
        lim = long_limit ? (1 << LONG_LOG) : (1 << SHORT_LOG);
        exp_req = (mc > 0) && !m_done[0] && order_ok;
        tgt_done = 1'b0; tgt_retry = 1'b0;
        if (exp_req) begin
            if (tgt_mode == 1) tgt_retry = 1'b1;
            else if (tgt_mode == 2) tgt_done = 1'b1;
            else if (tgt_mode == 3) begin
                r = $urandom % 10;
                if (r < 5) tgt_retry = 1'b1; else if (r < 7) tgt_done = 1'b1;
            end
        end
        #1;
        chk("R4 tgt_req", {31'b0, tgt_req}, {31'b0, exp_req});
        if (exp_req) begin
            chk("R2 R11 tgt_addr", tgt_addr, m_addr[0]);
            chk("R2 R11 tgt_cmd", {28'b0, tgt_cmd}, {28'b0, m_cmd[0]});
            chk("R4 tgt_be_n", {28'b0, tgt_be_n}, {28'b0, m_be[0]});
            chk("R4 tgt_data", tgt_data, m_data[0]);
        end
        dec = m_phase && irdy;
        comp = 0; dup = 0; push = 0; err = 0;
        if (dec) begin
            comp = (mc > 0) && m_done[0] && m_cmd[0] == m_ccmd && m_addr[0] == m_caddr &&
                   m_be[0] == be_n && masked_eq(m_data[0], data, be_n);
            for (int k = 0; k < mc; k++) if (m_cmd[k] == m_ccmd && m_addr[k] == m_caddr) dup = 1;
            push = !comp && !dup && (mc < DEPTH);
            if (!comp && dup) n_dup++;
        end
        if (exp_req && tgt_retry && ma >= lim - 1) err = 1;
        @(posedge clk); #1;
        chk(comp ? "R8 devsel" : "R1 devsel", {31'b0, devsel}, {31'b0, dec});
        chk(comp ? "R8 R9 trdy" : "R1 R9 trdy", {31'b0, trdy}, {31'b0, comp});
        chk(comp ? "R8 stop" : "R1 stop", {31'b0, stop}, {31'b0, dec && (!comp || multi)});
        chk(serr_en ? "R6 sys_err" : "R7 sys_err", {31'b0, sys_err}, {31'b0, err && serr_en});
        if (exp_req && tgt_done) begin m_done[0] = 1; ma = 0; end
        else if (exp_req && tgt_retry) ma = err ? 0 : ma + 1;
        if (comp) n_comp++;
        if (err) n_err++;
        if (comp || err) model_pop();
        if (push) begin
            m_cmd[mc] = m_ccmd; m_addr[mc] = m_caddr; m_be[mc] = be_n;
            m_data[mc] = data; m_done[mc] = 0; mc++;
        end
        if (frame && !m_phase) begin m_phase = 1; m_ccmd = cmd; m_caddr = addr; end
        else if (dec) m_phase = 0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        frame = 0; irdy = 0;
        repeat (n) step();
    endtask

    // Address cycle, data cycle (with garbage on cmd/addr), idle cycle.
    task automatic wr(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                      input logic [31:0] d, input logic m);
        frame = 1; irdy = 0; cmd = c; addr = a; step();
        frame = 0; irdy = 1; be_n = b; data = d; multi = m;
        cmd = 4'($urandom); addr = $urandom; step();
        irdy = 0; step();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [3:0] c, b;
        logic [31:0] a, d;
        int k, r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk("R12 reset tgt_req", {31'b0, tgt_req}, 32'h0);
        chk("R12 reset devsel", {29'b0, devsel, trdy, stop}, 32'h0);
        chk("R12 reset sys_err", {31'b0, sys_err}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R1 R2 R4: new write retried, queued, held back by ordering.
        order_ok = 0; tgt_mode = 0;
        wr(4'h3, 32'h100, 4'h0, 32'hCAFE_0001, 1'b0);
        idle(2);
        // R10: early repeat gets retry, no new entry.
        wr(4'h3, 32'h100, 4'h0, 32'hCAFE_0001, 1'b0);
        order_ok = 1; tgt_mode = 1; idle(2);     // R5 reissue after retries
        tgt_mode = 2; idle(1); tgt_mode = 0;
        // R8: multi-DWORD repeat completes with disconnect.
        wr(4'h3, 32'h100, 4'h0, 32'hCAFE_0001, 1'b1);
        idle(1);
        // R9: disabled bytes differ, still completes.
        wr(4'hB, 32'h104, 4'b0101, 32'h1122_3344, 1'b0);
        tgt_mode = 2; idle(1); tgt_mode = 0;
        wr(4'hB, 32'h104, 4'b0101, 32'h11AA_33BB, 1'b0);
        // R9: enabled byte differs, retried; exact repeat completes.
        wr(4'h3, 32'h108, 4'h0, 32'h5555_AAAA, 1'b0);
        tgt_mode = 2; idle(1); tgt_mode = 0;
        wr(4'h3, 32'h108, 4'h0, 32'h5555_ABAA, 1'b0);
        wr(4'h3, 32'h108, 4'h0, 32'h5555_AAAA, 1'b0);
        // R3 R11: fill the queue, one extra write is not kept.
        order_ok = 0;
        for (int i = 0; i < DEPTH + 1; i++) wr(4'h3, 32'h200 + 4 * i, 4'h0, 32'h7000 + i, 1'b0);
        chk("R3 R11 queue full", mc, DEPTH);
        order_ok = 1;
        for (int i = 0; i < DEPTH + 1; i++) begin
            tgt_mode = 2; idle(1); tgt_mode = 0;
            wr(4'h3, 32'h200 + 4 * i, 4'h0, 32'h7000 + i, 1'b0);
        end
        // R6: short limit with error reporting.
        serr_en = 1; long_limit = 0; tgt_mode = 1;
        idle(12);
        chk("R6 short limit drops", mc, 0);
        // R7: long limit without reporting.
        serr_en = 0; long_limit = 1; tgt_mode = 0;
        wr(4'h3, 32'h300, 4'h0, 32'h1, 1'b0);
        tgt_mode = 1; idle(40);
        chk("R7 long limit drops", mc, 0);
        chk("R6 R7 errors seen", {31'b0, n_err >= 2}, 32'h1);

        // Random traffic.
        tgt_mode = 3;
        for (int t = 0; t < 1500; t++) begin
            order_ok = ($urandom % 4) != 0;
            serr_en = $urandom % 2;
            long_limit = ($urandom % 10) == 0;
            if (mc > 0 && ($urandom % 2) == 1) begin
                k = $urandom % mc;
                c = m_cmd[k]; a = m_addr[k]; b = m_be[k]; d = m_data[k];
                r = $urandom % 4;
                if (r == 0) d = d ^ ($urandom & ~en_mask(b));
                else if (r == 1) d = d ^ ($urandom & en_mask(b));
            end else begin
                c = ($urandom % 2) ? 4'h3 : 4'hB;
                a = 32'h1000 + 4 * ($urandom % 6);
                b = 4'($urandom);
                d = $urandom;
            end
            wr(c, a, b, d, 1'($urandom));
            idle($urandom % 3);
        end
        chk("R8 completions seen", {31'b0, n_comp > 10}, 32'h1);
        chk("R6 errors seen", {31'b0, n_err > 2}, 32'h1);
        chk("R10 duplicates seen", {31'b0, n_dup > 10}, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule